// File: doc/BRIEF.md
# Half-Duplex Collision Retry Controller

This block supervises the transmission attempts of a single frame on a shared half-duplex medium. The transmit datapath tells it when a frame starts, when each byte leaves, and when the frame finishes; the PHY side reports collisions. From these inputs the controller decides whether a collision is early or late. An early collision either leads to another attempt after a randomized backoff or, once the attempt budget is spent, to discarding the frame. A late collision truncates the frame.

Early collisions start a backoff measured in slot times. The number of slots comes from a free-running LFSR, and an exponent that grows with the collision count bounds the range. Configuration can cap that exponent at a lower value, or remove the wait entirely. When the wait ends, the controller issues a one-cycle retry command and a fresh attempt begins. Both kinds of failure produce an abort command, a one-cycle cause event and a general transmit-error event. Every frame ends with a completion status that carries the frame's collision count. When the port runs in full duplex, the collision input has no effect.

Top module: `hdx_retry_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, every command, event and status output is low, backoff_busy is low and coll_cnt is 0.
- R2: A frame_start pulse while the controller is idle begins an attempt and clears coll_cnt to 0. The byte window also restarts at 0.
- R3: In half duplex, the byte count is the number of byte_sent strobes in earlier cycles of the current attempt. A coll_det while this count is at most cfg_coll_win is an early collision. In the cycle after it, coll_cnt has increased by one and backoff_busy is high, unless R8 applies.
- R4: With cfg_no_backoff set, backoff_busy stays high for exactly one cycle. The cycle after that one carries a one-cycle retry_cmd pulse.
- R5: With cfg_no_backoff clear, backoff_busy stays high for r*8+1 cycles (8 clock cycles per slot at the default). Here r is less than 2^min(n,10) and n is the collision count after the increment. retry_cmd pulses in the cycle in which backoff_busy falls.
- R6: With cfg_alt_trunc_en set, the exponent limit is cfg_alt_trunc instead of 10. With cfg_alt_trunc = 1, every backoff lasts either 1 or 9 cycles.
- R7: A coll_det while the byte count exceeds cfg_coll_win is a late collision. In the next cycle ev_late_coll, ev_tx_err and abort_cmd pulse for one cycle. stat_vld reports stat_code 1 with coll_cnt unchanged, and the controller returns to idle with no retry.
- R8: An early collision that would raise coll_cnt above cfg_retry_max discards the frame. In the next cycle ev_retry_lim, ev_tx_err and abort_cmd pulse, and stat_vld reports stat_code 2 with coll_cnt = cfg_retry_max+1. backoff_busy stays low.
- R9: With cfg_half_duplex low, coll_det is ignored: no event, no abort, no backoff, and coll_cnt does not change.
- R10: frame_end during an attempt produces a one-cycle stat_vld with stat_code 0 and the frame's coll_cnt, and returns the controller to idle.
- R11: coll_det during a backoff wait is ignored. coll_cnt is the same after the retry as it was when the wait began.
- R12: A retry restarts the byte window. After the retry, a collision that follows cfg_coll_win new bytes is still early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half_duplex | input | 1 | 1 = half duplex, collision handling active |
| cfg_retry_max | input | 4 | Largest collision count still followed by a retry |
| cfg_coll_win | input | 10 | Last byte count at which a collision is early |
| cfg_no_backoff | input | 1 | Retry immediately, without a random wait |
| cfg_alt_trunc_en | input | 1 | Use cfg_alt_trunc as the exponent limit |
| cfg_alt_trunc | input | 4 | Alternate exponent limit |
| frame_start | input | 1 | Datapath begins a new frame |
| byte_sent | input | 1 | One byte transmitted this cycle |
| coll_det | input | 1 | Collision detected on the medium |
| frame_end | input | 1 | Frame fully transmitted |
| retry_cmd | output | 1 | One-cycle command to restart the frame |
| abort_cmd | output | 1 | One-cycle command to truncate or discard the frame |
| backoff_busy | output | 1 | Backoff wait in progress |
| ev_late_coll | output | 1 | One-cycle late-collision event |
| ev_retry_lim | output | 1 | One-cycle retry-limit event |
| ev_tx_err | output | 1 | One-cycle general transmit-error event |
| stat_vld | output | 1 | Frame completion status valid |
| stat_code | output | 2 | 0 sent, 1 late collision, 2 retry limit |
| coll_cnt | output | 5 | Collisions of the current frame |

## Verification
The bench places collisions exactly at the window edge and one byte past it. A design off by one in the byte comparison would turn the edge case into a late collision, or would miss the truncation one byte later. It drives the retry limit to its edge, where a design that compares before incrementing would grant one attempt too many. It also injects collisions in the middle of a backoff and in full duplex; a design that reacts would show a changed count or spurious events. Measured backoff lengths are checked against slot granularity and the truncated exponent range, so a wrong cap or a wait that is one cycle too long is detected.

// File: rtl/hdx_retry_pkg.sv
package hdx_retry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XMIT = 2'd1,
    ST_WAIT = 2'd2
  } hdx_state_e;

  typedef enum logic [1:0] {
    STAT_OK    = 2'd0,
    STAT_LATE  = 2'd1,
    STAT_LIMIT = 2'd2
  } hdx_stat_e;
endpackage

// File: rtl/hdx_byte_window.sv
module hdx_byte_window #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_sent,
  input  logic [WIN_W-1:0] cfg_win,
  output logic             past_win
);
  localparam int CW = WIN_W + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (byte_sent & ~(&cnt_q));
    cnt_d  = clr ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign past_win = cnt_q > {1'b0, cfg_win};

  a_r7_cnt_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/hdx_backoff_draw.sv
module hdx_backoff_draw #(
  parameter int              CNT_W     = 5,
  parameter int              R_W       = 15,
  parameter int              EXP_STD   = 10,
  parameter int              LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] coll_n,
  input  logic             cfg_no_backoff,
  input  logic             cfg_alt_en,
  input  logic [CNT_W-2:0] cfg_alt_exp,
  output logic [R_W-1:0]   draw
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic [CNT_W-1:0]  cap, k;
  logic [R_W-1:0]    mask;

  always_comb begin
    lfsr_d = {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? LFSR_TAPS : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= LFSR_SEED;
    else        lfsr_q <= lfsr_d;
  end

  always_comb begin
    cap = cfg_alt_en ? {1'b0, cfg_alt_exp} : CNT_W'(EXP_STD);
    k   = (coll_n < cap) ? coll_n : cap;
  end

  for (genvar i = 0; i < R_W; i++) begin : g_mask
    assign mask[i] = CNT_W'(i) < k;
  end

  assign draw = cfg_no_backoff ? '0 : (lfsr_q[R_W-1:0] & mask);

  a_r5_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/hdx_slot_timer.sv
module hdx_slot_timer #(
  parameter int SLOT_CYCLES = 8,
  parameter int R_W         = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [R_W-1:0] load_slots,
  input  logic           active,
  output logic           expired
);
  localparam int TICK_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [TICK_W-1:0] TICK_TOP = TICK_W'(SLOT_CYCLES - 1);

  logic [R_W-1:0]    slots_q, slots_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              tmr_en;

  always_comb begin
    tmr_en  = load | (active & (slots_q != '0));
    slots_d = slots_q;
    tick_d  = tick_q;
    if (load) begin
      slots_d = load_slots;
      tick_d  = TICK_TOP;
    end else if (tick_q == '0) begin
      slots_d = slots_q - R_W'(1);
      tick_d  = TICK_TOP;
    end else begin
      tick_d  = tick_q - TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q <= '0;
      tick_q  <= '0;
    end else if (tmr_en) begin
      slots_q <= slots_d;
      tick_q  <= tick_d;
    end
  end

  assign expired = slots_q == '0;

  a_r5_slots_down: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> slots_q <= $past(slots_q));
endmodule

// File: rtl/hdx_retry_ctrl.sv
module hdx_retry_ctrl
  import hdx_retry_pkg::*;
#(
  parameter int RETRY_W     = 4,
  parameter int WIN_W       = 10,
  parameter int SLOT_CYCLES = 8,
  parameter int EXP_STD     = 10,
  parameter int LFSR_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_half_duplex,
  input  logic [RETRY_W-1:0] cfg_retry_max,
  input  logic [WIN_W-1:0]   cfg_coll_win,
  input  logic               cfg_no_backoff,
  input  logic               cfg_alt_trunc_en,
  input  logic [RETRY_W-1:0] cfg_alt_trunc,
  input  logic               frame_start,
  input  logic               byte_sent,
  input  logic               coll_det,
  input  logic               frame_end,
  output logic               retry_cmd,
  output logic               abort_cmd,
  output logic               backoff_busy,
  output logic               ev_late_coll,
  output logic               ev_retry_lim,
  output logic               ev_tx_err,
  output logic               stat_vld,
  output logic [1:0]         stat_code,
  output logic [RETRY_W:0]   coll_cnt
);
  localparam int CNT_W = RETRY_W + 1;
  localparam int R_W   = (1 << RETRY_W) - 1;

  hdx_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, coll_inc;
  logic             retry_d, abort_d, late_d, lim_d, stat_vld_d;
  logic [1:0]       stat_code_d;
  logic             win_clr, past_win, tmr_load, tmr_expired;
  logic [R_W-1:0]   draw;

  hdx_byte_window #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .byte_sent(byte_sent),
    .cfg_win(cfg_coll_win), .past_win(past_win)
  );

  hdx_backoff_draw #(
    .CNT_W(CNT_W), .R_W(R_W), .EXP_STD(EXP_STD), .LFSR_W(LFSR_W)
  ) u_draw (
    .clk(clk), .rst_n(rst_n), .coll_n(coll_inc),
    .cfg_no_backoff(cfg_no_backoff), .cfg_alt_en(cfg_alt_trunc_en),
    .cfg_alt_exp(cfg_alt_trunc), .draw(draw)
  );

  hdx_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES), .R_W(R_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_slots(draw),
    .active(state_q == ST_WAIT), .expired(tmr_expired)
  );

  assign coll_inc = cnt_q + CNT_W'(1);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    retry_d     = 1'b0;
    abort_d     = 1'b0;
    late_d      = 1'b0;
    lim_d       = 1'b0;
    stat_vld_d  = 1'b0;
    stat_code_d = stat_code;
    win_clr     = 1'b0;
    tmr_load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (frame_start) begin
          state_d = ST_XMIT;
          cnt_d   = '0;
          win_clr = 1'b1;
        end
      end
      ST_XMIT: begin
        if (coll_det && cfg_half_duplex) begin
          if (past_win) begin
            late_d      = 1'b1;
            abort_d     = 1'b1;
            stat_vld_d  = 1'b1;
            stat_code_d = STAT_LATE;
            state_d     = ST_IDLE;
          end else if (coll_inc > {1'b0, cfg_retry_max}) begin
            cnt_d       = coll_inc;
            lim_d       = 1'b1;
            abort_d     = 1'b1;
            stat_vld_d  = 1'b1;
            stat_code_d = STAT_LIMIT;
            state_d     = ST_IDLE;
          end else begin
            cnt_d    = coll_inc;
            tmr_load = 1'b1;
            state_d  = ST_WAIT;
          end
        end else if (frame_end) begin
          stat_vld_d  = 1'b1;
          stat_code_d = STAT_OK;
          state_d     = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (tmr_expired) begin
          retry_d = 1'b1;
          win_clr = 1'b1;
          state_d = ST_XMIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      retry_cmd    <= 1'b0;
      abort_cmd    <= 1'b0;
      ev_late_coll <= 1'b0;
      ev_retry_lim <= 1'b0;
      ev_tx_err    <= 1'b0;
      stat_vld     <= 1'b0;
      stat_code    <= STAT_OK;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      retry_cmd    <= retry_d;
      abort_cmd    <= abort_d;
      ev_late_coll <= late_d;
      ev_retry_lim <= lim_d;
      ev_tx_err    <= late_d | lim_d;
      stat_vld     <= stat_vld_d;
      stat_code    <= stat_code_d;
    end
  end

  assign backoff_busy = state_q == ST_WAIT;
  assign coll_cnt     = cnt_q;

  a_r8_abort_excl_retry: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_cmd && retry_cmd));
  a_r7_late_raises_err: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late_coll |-> ev_tx_err && abort_cmd && stat_vld);
  a_r8_limit_raises_err: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry_lim |-> ev_tx_err && abort_cmd && !backoff_busy);
  a_r7_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_late_coll, ev_retry_lim}));
  a_r12_retry_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    retry_cmd |-> $past(backoff_busy) && !backoff_busy);
  a_r3_busy_bumps_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(backoff_busy) |-> coll_cnt == CNT_W'($past(coll_cnt) + 1'b1));
  a_r9_fdx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_half_duplex && !backoff_busy |=> !backoff_busy && !ev_tx_err);
  a_r11_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_busy && $past(backoff_busy) |-> $stable(coll_cnt));
endmodule

// File: tb/hdx_retry_ctrl_tb_top.sv
module hdx_retry_ctrl_tb_top;
  localparam int SLOT = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_half_duplex = 1'b1;
  logic [3:0] cfg_retry_max = 4'd15;
  logic [9:0] cfg_coll_win = 10'd55;
  logic       cfg_no_backoff = 1'b1;
  logic       cfg_alt_trunc_en = 1'b0;
  logic [3:0] cfg_alt_trunc = 4'd10;
  logic       frame_start = 1'b0, byte_sent = 1'b0, coll_det = 1'b0, frame_end = 1'b0;
  logic       retry_cmd, abort_cmd, backoff_busy, ev_late_coll, ev_retry_lim, ev_tx_err, stat_vld;
  logic [1:0] stat_code;
  logic [4:0] coll_cnt;

  always #4 clk = ~clk;

  hdx_retry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_half_duplex(cfg_half_duplex),
    .cfg_retry_max(cfg_retry_max), .cfg_coll_win(cfg_coll_win),
    .cfg_no_backoff(cfg_no_backoff), .cfg_alt_trunc_en(cfg_alt_trunc_en),
    .cfg_alt_trunc(cfg_alt_trunc), .frame_start(frame_start), .byte_sent(byte_sent),
    .coll_det(coll_det), .frame_end(frame_end), .retry_cmd(retry_cmd),
    .abort_cmd(abort_cmd), .backoff_busy(backoff_busy), .ev_late_coll(ev_late_coll),
    .ev_retry_lim(ev_retry_lim), .ev_tx_err(ev_tx_err), .stat_vld(stat_vld),
    .stat_code(stat_code), .coll_cnt(coll_cnt)
  );

  typedef struct { int code; int cnt; string req; } exp_t;
  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic push(int code, int cnt, string req);
    exp_t e;
    e.code = code; e.cnt = cnt; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic start_frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
  endtask

  task automatic send_bytes(int n);
    for (int i = 0; i < n; i++) begin byte_sent = 1'b1; tick(); end
    byte_sent = 1'b0;
  endtask

  task automatic collide();
    coll_det = 1'b1; tick(); coll_det = 1'b0;
  endtask

  task automatic end_frame(int cnt, string req);
    push(0, cnt, req);
    frame_end = 1'b1; tick(); frame_end = 1'b0;
  endtask

  task automatic wait_backoff(output int len, input bit inject);
    len = 0;
    while (backoff_busy) begin
      if (inject && len == 0) coll_det = 1'b1;
      len++;
      tick();
      coll_det = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && stat_vld) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10 unexpected status actual=%0d expected=none", stat_code);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.req, "stat_code", int'(stat_code), e.code);
        chk(e.req, "status coll_cnt", int'(coll_cnt), e.cnt);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int len;
    repeat (3) tick();
    // R1 reset state
    chk("R1", "outputs in reset", int'({retry_cmd, abort_cmd, backoff_busy, ev_late_coll,
        ev_retry_lim, ev_tx_err, stat_vld}), 0);
    chk("R1", "coll_cnt in reset", int'(coll_cnt), 0);
    rst_n = 1'b1;
    tick(); tick();
    chk("R1", "outputs after reset", int'({retry_cmd, abort_cmd, backoff_busy, stat_vld}), 0);

    // R2, R10 clean frame
    start_frame();
    chk("R2", "coll_cnt at start", int'(coll_cnt), 0);
    send_bytes(5);
    end_frame(0, "R10");
    tick();

    // R3, R4, R12 no-backoff retries, window edge
    cfg_coll_win = 10'd4;
    start_frame();
    send_bytes(4);
    collide();
    chk("R3", "busy after early collision", int'(backoff_busy), 1);
    chk("R3", "coll_cnt after early collision", int'(coll_cnt), 1);
    chk("R3", "no abort on early collision", int'(abort_cmd), 0);
    tick();
    chk("R4", "busy one cycle", int'(backoff_busy), 0);
    chk("R4", "retry pulse", int'(retry_cmd), 1);
    send_bytes(4);
    chk("R4", "retry one cycle", int'(retry_cmd), 0);
    collide();
    chk("R12", "window restarted, still early", int'(backoff_busy), 1);
    chk("R12", "no late event", int'(ev_late_coll), 0);
    tick();
    end_frame(2, "R10");
    tick();

    // R7 late collision one byte past window
    start_frame();
    send_bytes(5);
    push(1, 0, "R7");
    collide();
    chk("R7", "late event", int'(ev_late_coll), 1);
    chk("R7", "tx error", int'(ev_tx_err), 1);
    chk("R7", "abort", int'(abort_cmd), 1);
    chk("R7", "no backoff", int'(backoff_busy), 0);
    tick();
    chk("R7", "late one cycle", int'(ev_late_coll), 0);
    chk("R7", "no retry", int'(retry_cmd), 0);

    // R8 retry limit
    cfg_retry_max = 4'd2;
    start_frame();
    collide(); tick();
    collide(); tick();
    chk("R8", "second retry allowed", int'(retry_cmd), 1);
    push(2, 3, "R8");
    collide();
    chk("R8", "limit event", int'(ev_retry_lim), 1);
    chk("R8", "tx error", int'(ev_tx_err), 1);
    chk("R8", "abort", int'(abort_cmd), 1);
    chk("R8", "no backoff", int'(backoff_busy), 0);
    tick();
    chk("R8", "no retry after discard", int'(retry_cmd), 0);
    cfg_retry_max = 4'd15;

    // R9 full duplex ignores collisions
    cfg_half_duplex = 1'b0;
    start_frame();
    send_bytes(2);
    collide();
    chk("R9", "no busy", int'(backoff_busy), 0);
    chk("R9", "no event", int'({ev_late_coll, ev_retry_lim, ev_tx_err, abort_cmd}), 0);
    send_bytes(10);
    collide();
    chk("R9", "no late in full duplex", int'(ev_late_coll), 0);
    chk("R9", "count unchanged", int'(coll_cnt), 0);
    end_frame(0, "R9");
    tick();
    cfg_half_duplex = 1'b1;

    // R5, R11 standard backoff
    cfg_no_backoff = 1'b0;
    start_frame();
    for (int n = 1; n <= 6; n++) begin
      send_bytes(2);
      collide();
      chk("R3", "coll_cnt per collision", int'(coll_cnt), n);
      wait_backoff(len, n <= 2);
      chk("R5", "retry at end of wait", int'(retry_cmd), 1);
      chk("R5", "slot granularity", (len - 1) % SLOT, 0);
      chk("R5", "slots within range", int'(((len - 1) / SLOT) < (1 << n)), 1);
      chk("R11", "count unchanged by collision in wait", int'(coll_cnt), n);
    end
    end_frame(6, "R5");
    tick();

    // R6 alternate truncation to exponent 1
    cfg_alt_trunc_en = 1'b1;
    cfg_alt_trunc = 4'd1;
    start_frame();
    for (int n = 1; n <= 5; n++) begin
      collide();
      wait_backoff(len, 1'b0);
      chk("R6", "truncated backoff length", int'(len == 1 || len == SLOT + 1), 1);
      chk("R6", "retry after wait", int'(retry_cmd), 1);
    end
    end_frame(5, "R6");
    tick(); tick();

    chk("R10", "status queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule